// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Control

This block steers operands and freezes the front end of a five-stage in-order integer pipeline. For each of the two source operands of the instruction now sitting in the execute stage, it compares the register number against the destination numbers carried by the two stages ahead of it. It then picks where the ALU input should come from: the register file, the result waiting to retire, or the ALU result one stage ahead. When the newest producer is still in flight, the nearer stage wins.

A load is different. Its data appears only at the end of the memory stage, so an instruction that reads the loaded register directly after the load cannot be served by bypassing. The unit spots this pairing while the load sits in ID/EX and its consumer sits in IF/ID. It then raises a hold that freezes the program counter and IF/ID, and a flush that clears the control bits entering ID/EX, so exactly one bubble enters the pipe. A consumer two instructions behind a load is served by the retire-stage bypass. A consumer three behind is served by a small register file that writes in the first half of the cycle and reads in the second. Here, a write in a cycle is visible on a read port in the same cycle.

Top module: `fwd_interlock_unit`

## Requirements
- R1: When the EX/MEM stage is valid, writes a register, and its destination is nonzero and equal to an execute-stage source, that operand's select is 2'b10.
- R2: When only the MEM/WB stage is valid, writes a register, and has a nonzero destination equal to an execute-stage source, that operand's select is 2'b01. With no match the select is 2'b00 (register file).
- R3: When both later stages match the same source, the select is 2'b10, so the newer value takes priority.
- R4: Register 0 never produces a forward select or a stall, and it always reads as zero from the register file.
- R5: A stage whose valid bit is clear never causes a forward or a stall. This holds whether it is the consumer (execute or decode) or a producer.
- R6: A valid load in ID/EX with a nonzero destination equal to either source of a valid instruction in IF/ID raises both hold_front and flush_idex in that same cycle.
- R7: A load held in EX/MEM never causes a stall. Its consumer is served by forwarding alone.
- R8: A register-file write in a cycle is returned in that same cycle by a read port that names the written register.
- R9: Reset clears every register-file entry to zero.
- R10: An ID/EX instruction that is not a load (mem-read flag clear) never causes a stall, even when its destination matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | IF/ID holds a live instruction |
| id_rs_a | input | 5 | First source register of the IF/ID instruction |
| id_rs_b | input | 5 | Second source register of the IF/ID instruction |
| ex_valid | input | 1 | ID/EX holds a live instruction |
| ex_rs_a | input | 5 | First source register in ID/EX |
| ex_rs_b | input | 5 | Second source register in ID/EX |
| ex_rd | input | 5 | Destination register in ID/EX |
| ex_mem_rd | input | 1 | ID/EX instruction is a load |
| mem_valid | input | 1 | EX/MEM holds a live instruction |
| mem_rd | input | 5 | Destination register in EX/MEM |
| mem_reg_wr | input | 1 | EX/MEM instruction writes a register |
| wb_valid | input | 1 | MEM/WB holds a live instruction |
| wb_rd | input | 5 | Destination register in MEM/WB |
| wb_reg_wr | input | 1 | MEM/WB instruction writes a register |
| wb_data | input | 32 | Value being written back |
| fwd_sel_a | output | 2 | Operand A source: 00 register file, 01 MEM/WB, 10 EX/MEM |
| fwd_sel_b | output | 2 | Operand B source, same encoding |
| hold_front | output | 1 | Freeze PC and IF/ID this cycle |
| flush_idex | output | 1 | Clear ID/EX control bits (insert bubble) |
| rf_data_a | output | 32 | Register-file read of id_rs_a |
| rf_data_b | output | 32 | Register-file read of id_rs_b |

## Verification
Two functions can meet in one cycle. A load in ID/EX can be found to need an interlock while, in the same cycle, the instruction in MEM/WB writes back a register that the IF/ID consumer also reads through the register file. The random phase draws register numbers from a narrow range so that load-use pairs, double forwarding matches and same-cycle write-and-read collide often. The reference model judges each cycle on its own terms: the stall pair against the load and consumer fields, and the read data against its own register array plus the write in flight.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    parameter int unsigned REG_COUNT = 32;
    parameter int unsigned DATA_W    = 32;
    parameter int unsigned NUM_SRC   = 2;
    localparam int unsigned IDX_W    = $clog2(REG_COUNT);

    typedef logic [IDX_W-1:0]  reg_idx_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        OPND_FROM_RF  = 2'b00,
        OPND_FROM_WB  = 2'b01,
        OPND_FROM_MEM = 2'b10
    } opnd_sel_e;

    typedef struct packed {
        logic     valid;
        logic     wr_en;
        reg_idx_t dst;
    } producer_t;

    function automatic logic produces_for(producer_t p, reg_idx_t src);
        return p.valid && p.wr_en && (p.dst != '0) && (p.dst == src);
    endfunction
endpackage

// File: rtl/opnd_bypass_sel.sv
module opnd_bypass_sel
    import hzd_pkg::*;
(
    input  logic      use_valid,
    input  reg_idx_t  src,
    input  producer_t near_prod,
    input  producer_t far_prod,
    output opnd_sel_e sel
);
    logic near_hit;
    logic far_hit;

    always_comb begin
        near_hit = use_valid && produces_for(near_prod, src);
        far_hit  = use_valid && produces_for(far_prod, src);
        if (near_hit)      sel = OPND_FROM_MEM;
        else if (far_hit)  sel = OPND_FROM_WB;
        else               sel = OPND_FROM_RF;
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
    import hzd_pkg::*;
(
    input  logic     load_valid,
    input  logic     load_is_mem_rd,
    input  reg_idx_t load_dst,
    input  logic     cons_valid,
    input  reg_idx_t cons_src [NUM_SRC],
    output logic     hit
);
    logic [NUM_SRC-1:0] per_src;
    producer_t          ld;

    always_comb begin
        ld.valid = load_valid && cons_valid;
        ld.wr_en = load_is_mem_rd;
        ld.dst   = load_dst;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign per_src[s] = produces_for(ld, cons_src[s]);
    end

    assign hit = |per_src;
endmodule

// File: rtl/wbr_regfile.sv
module wbr_regfile
    import hzd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  reg_idx_t wr_idx,
    input  word_t    wr_val,
    input  reg_idx_t rd_idx [NUM_SRC],
    output word_t    rd_val [NUM_SRC]
);
    word_t store [REG_COUNT];
    logic  wr_live;

    assign wr_live = wr_en && (wr_idx != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(REG_COUNT); i++) store[i] <= '0;
        end else if (wr_live) begin
            store[wr_idx] <= wr_val;
        end
    end

    for (genvar p = 0; p < NUM_SRC; p++) begin : g_port
        always_comb begin
            if (rd_idx[p] == '0)                      rd_val[p] = '0;
            else if (wr_live && wr_idx == rd_idx[p])  rd_val[p] = wr_val;
            else                                      rd_val[p] = store[rd_idx[p]];
        end
    end
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
    import hzd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  id_valid,
    input  logic [IDX_W-1:0]      id_rs_a,
    input  logic [IDX_W-1:0]      id_rs_b,
    input  logic                  ex_valid,
    input  logic [IDX_W-1:0]      ex_rs_a,
    input  logic [IDX_W-1:0]      ex_rs_b,
    input  logic [IDX_W-1:0]      ex_rd,
    input  logic                  ex_mem_rd,
    input  logic                  mem_valid,
    input  logic [IDX_W-1:0]      mem_rd,
    input  logic                  mem_reg_wr,
    input  logic                  wb_valid,
    input  logic [IDX_W-1:0]      wb_rd,
    input  logic                  wb_reg_wr,
    input  logic [DATA_W-1:0]     wb_data,
    output logic [1:0]            fwd_sel_a,
    output logic [1:0]            fwd_sel_b,
    output logic                  hold_front,
    output logic                  flush_idex,
    output logic [DATA_W-1:0]     rf_data_a,
    output logic [DATA_W-1:0]     rf_data_b
);
    producer_t near_p;
    producer_t far_p;
    reg_idx_t  ex_src [NUM_SRC];
    reg_idx_t  id_src [NUM_SRC];
    opnd_sel_e sel    [NUM_SRC];
    word_t     rd_val [NUM_SRC];
    logic      lu_hit;

    always_comb begin
        near_p.valid = mem_valid;
        near_p.wr_en = mem_reg_wr;
        near_p.dst   = mem_rd;
        far_p.valid  = wb_valid;
        far_p.wr_en  = wb_reg_wr;
        far_p.dst    = wb_rd;
        ex_src[0]    = ex_rs_a;
        ex_src[1]    = ex_rs_b;
        id_src[0]    = id_rs_a;
        id_src[1]    = id_rs_b;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_opnd
        opnd_bypass_sel u_sel (
            .use_valid (ex_valid),
            .src       (ex_src[s]),
            .near_prod (near_p),
            .far_prod  (far_p),
            .sel       (sel[s])
        );
    end

    load_use_detect u_lu (
        .load_valid     (ex_valid),
        .load_is_mem_rd (ex_mem_rd),
        .load_dst       (ex_rd),
        .cons_valid     (id_valid),
        .cons_src       (id_src),
        .hit            (lu_hit)
    );

    wbr_regfile u_rf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wb_valid && wb_reg_wr),
        .wr_idx (wb_rd),
        .wr_val (wb_data),
        .rd_idx (id_src),
        .rd_val (rd_val)
    );

    assign fwd_sel_a  = sel[0];
    assign fwd_sel_b  = sel[1];
    assign hold_front = lu_hit;
    assign flush_idex = lu_hit;
    assign rf_data_a  = rd_val[0];
    assign rf_data_b  = rd_val[1];
endmodule

// File: rtl/fwd_interlock_chk.sv
module fwd_interlock_chk
    import hzd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              id_valid,
    input logic [IDX_W-1:0]  id_rs_a,
    input logic [IDX_W-1:0]  id_rs_b,
    input logic              ex_valid,
    input logic [IDX_W-1:0]  ex_rs_a,
    input logic [IDX_W-1:0]  ex_rs_b,
    input logic [IDX_W-1:0]  ex_rd,
    input logic              ex_mem_rd,
    input logic              mem_valid,
    input logic [IDX_W-1:0]  mem_rd,
    input logic              mem_reg_wr,
    input logic              wb_valid,
    input logic [IDX_W-1:0]  wb_rd,
    input logic              wb_reg_wr,
    input logic [DATA_W-1:0] wb_data,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b,
    input logic              hold_front,
    input logic              flush_idex,
    input logic [DATA_W-1:0] rf_data_a,
    input logic [DATA_W-1:0] rf_data_b
);
    p_near_fwd_source_r1: assert property (@(posedge clk) disable iff (rst)
        fwd_sel_a == 2'b10 |-> mem_valid && mem_reg_wr && mem_rd == ex_rs_a);

    p_far_fwd_source_r2: assert property (@(posedge clk) disable iff (rst)
        fwd_sel_b == 2'b01 |-> wb_valid && wb_reg_wr && wb_rd == ex_rs_b);

    p_far_yields_r3: assert property (@(posedge clk) disable iff (rst)
        fwd_sel_a == 2'b01 |-> !(mem_valid && mem_reg_wr && mem_rd == ex_rs_a));

    p_zero_no_fwd_r4: assert property (@(posedge clk) disable iff (rst)
        ex_rs_a == '0 |-> fwd_sel_a == 2'b00);

    p_zero_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
        id_rs_b == '0 |-> rf_data_b == '0);

    p_idle_ex_r5: assert property (@(posedge clk) disable iff (rst)
        !ex_valid |-> fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00 && !hold_front);

    p_idle_id_r5: assert property (@(posedge clk) disable iff (rst)
        !id_valid |-> !hold_front);

    p_hold_with_flush_r6: assert property (@(posedge clk) disable iff (rst)
        hold_front |-> flush_idex);

    p_flush_with_hold_r6: assert property (@(posedge clk) disable iff (rst)
        flush_idex |-> hold_front);

    p_write_through_r8: assert property (@(posedge clk) disable iff (rst)
        wb_valid && wb_reg_wr && wb_rd != '0 && id_rs_a == wb_rd |-> rf_data_a == wb_data);

    p_cleared_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && !(wb_valid && wb_reg_wr) |-> rf_data_a == '0 && rf_data_b == '0);

    p_stall_needs_load_r10: assert property (@(posedge clk) disable iff (rst)
        hold_front |-> ex_mem_rd && ex_valid);
endmodule

bind fwd_interlock_unit fwd_interlock_chk u_chk (.*);

// File: tb/tb_fwd_interlock_unit.sv
module tb_fwd_interlock_unit;
    import hzd_pkg::*;
    localparam int PERIOD = 10;
    localparam int NREG   = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              id_valid, ex_valid, ex_mem_rd, mem_valid, mem_reg_wr, wb_valid, wb_reg_wr;
    logic [4:0]        id_rs_a, id_rs_b, ex_rs_a, ex_rs_b, ex_rd, mem_rd, wb_rd;
    logic [31:0]       wb_data;
    logic [1:0]        fwd_sel_a, fwd_sel_b;
    logic              hold_front, flush_idex;
    logic [31:0]       rf_data_a, rf_data_b;

    int          n_run  = 0;
    int          n_fail = 0;
    logic [31:0] model_rf [NREG];

    always #(PERIOD/2) clk = ~clk;

    fwd_interlock_unit dut (.*);

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_sel(logic [4:0] s);
        if (!ex_valid || s == 0) return 2'b00;
        if (mem_valid && mem_reg_wr && mem_rd == s) return 2'b10;
        if (wb_valid && wb_reg_wr && wb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string sel_tag(logic [4:0] s);
        logic nm, fm;
        nm = mem_valid && mem_reg_wr && mem_rd == s;
        fm = wb_valid && wb_reg_wr && wb_rd == s;
        if (s == 0) return "R4";
        if (!ex_valid || (mem_rd == s && !mem_valid) || (wb_rd == s && !wb_valid)) return "R5";
        if (nm && fm) return "R3";
        if (fm) return "R2";
        return "R1";
    endfunction

    function automatic logic [31:0] exp_rd(logic [4:0] s);
        if (s == 0) return 32'h0;
        if (wb_valid && wb_reg_wr && wb_rd == s) return wb_data;
        return model_rf[s];
    endfunction

    task automatic check_cycle();
        logic exp_stall;
        logic rd_match;
        string tag;
        rd_match  = (ex_rd == id_rs_a) || (ex_rd == id_rs_b);
        exp_stall = id_valid && ex_valid && ex_mem_rd && ex_rd != 0 && rd_match;
        if (exp_stall)                          tag = "R6";
        else if (rd_match && ex_rd == 0)        tag = "R4";
        else if (rd_match && (!ex_valid || !id_valid)) tag = "R5";
        else if (rd_match && !ex_mem_rd)        tag = "R10";
        else                                    tag = "R7";
        check(sel_tag(ex_rs_a), "fwd_sel_a", 32'(fwd_sel_a), 32'(exp_sel(ex_rs_a)));
        check(sel_tag(ex_rs_b), "fwd_sel_b", 32'(fwd_sel_b), 32'(exp_sel(ex_rs_b)));
        check(tag, "hold_front", 32'(hold_front), 32'(exp_stall));
        check(tag, "flush_idex", 32'(flush_idex), 32'(exp_stall));
        check(id_rs_a == 0 ? "R4" : "R8", "rf_data_a", rf_data_a, exp_rd(id_rs_a));
        check(id_rs_b == 0 ? "R4" : "R8", "rf_data_b", rf_data_b, exp_rd(id_rs_b));
    endtask

    task automatic commit();
        if (wb_valid && wb_reg_wr && wb_rd != 0) model_rf[wb_rd] = wb_data;
    endtask

    task automatic idle_inputs();
        {id_valid, ex_valid, ex_mem_rd, mem_valid, mem_reg_wr, wb_valid, wb_reg_wr} = '0;
        {id_rs_a, id_rs_b, ex_rs_a, ex_rs_b, ex_rd, mem_rd, wb_rd} = '0;
        wb_data = '0;
    endtask

    task automatic step();
        #1;
        check_cycle();
        commit();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle_inputs();
        repeat (2) @(negedge clk);
        for (int i = 0; i < NREG; i++) model_rf[i] = '0;
        rst = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        @(negedge clk);
        do_reset();
        // R9: all entries read zero after reset
        for (int r = 0; r < NREG; r += 2) begin
            id_rs_a = 5'(r); id_rs_b = 5'(r + 1);
            #1;
            check("R9", "rf_data_a after reset", rf_data_a, 32'h0);
            check("R9", "rf_data_b after reset", rf_data_b, 32'h0);
            @(negedge clk);
        end
        idle_inputs();

        // R1: EX/MEM match on operand A
        ex_valid = 1; ex_rs_a = 5; ex_rs_b = 6; mem_valid = 1; mem_reg_wr = 1; mem_rd = 5;
        step();
        // R3: both stages match operand B, EX/MEM wins
        mem_rd = 6; wb_valid = 1; wb_reg_wr = 1; wb_rd = 6; wb_data = 32'hCAFE0006;
        step();
        // R2: only MEM/WB matches
        mem_rd = 9; wb_rd = 5; wb_data = 32'h00000555;
        step();
        // R4: register 0 never forwards
        ex_rs_a = 0; mem_rd = 0; wb_rd = 0;
        step();
        // R5: invalid producer does not forward
        ex_rs_a = 7; mem_rd = 7; mem_valid = 0; wb_valid = 0;
        step();
        idle_inputs();
        // R6: load in ID/EX, consumer in IF/ID uses loaded reg on operand B
        ex_valid = 1; ex_mem_rd = 1; ex_rd = 4; id_valid = 1; id_rs_a = 2; id_rs_b = 4;
        step();
        // R10: same match, not a load
        ex_mem_rd = 0;
        step();
        // R5: consumer invalid, load matches
        ex_mem_rd = 1; id_valid = 0;
        step();
        // R7: load held in EX/MEM, consumer in IF/ID: no stall
        idle_inputs();
        mem_valid = 1; mem_reg_wr = 1; mem_rd = 4; id_valid = 1; id_rs_a = 4;
        step();
        // R8: same-cycle write-through then stored value
        idle_inputs();
        wb_valid = 1; wb_reg_wr = 1; wb_rd = 12; wb_data = 32'h12345678; id_rs_a = 12; id_rs_b = 12;
        step();
        wb_valid = 0;
        step();

        // random phase on a narrow register range
        for (int c = 0; c < 3000; c++) begin
            id_valid   = ($urandom_range(0, 7) != 0);
            ex_valid   = ($urandom_range(0, 7) != 0);
            mem_valid  = ($urandom_range(0, 7) != 0);
            wb_valid   = ($urandom_range(0, 7) != 0);
            ex_mem_rd  = $urandom_range(0, 1) == 1;
            mem_reg_wr = $urandom_range(0, 3) != 0;
            wb_reg_wr  = $urandom_range(0, 3) != 0;
            id_rs_a = 5'($urandom_range(0, 4)); id_rs_b = 5'($urandom_range(0, 4));
            ex_rs_a = 5'($urandom_range(0, 4)); ex_rs_b = 5'($urandom_range(0, 4));
            ex_rd   = 5'($urandom_range(0, 4)); mem_rd  = 5'($urandom_range(0, 4));
            wb_rd   = 5'($urandom_range(0, 4)); wb_data = $urandom;
            step();
        end

        // R9: reset after data was written clears it again
        do_reset();
        for (int r = 1; r < 5; r++) begin
            id_rs_a = 5'(r); id_rs_b = 5'(r);
            #1;
            check("R9", "rf_data_a after second reset", rf_data_a, 32'h0);
            @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule